// File: doc/BRIEF.md
# Track-Line Cache Directory

This block is the tag directory for a second-level disk cache whose lines are whole disk tracks. It keeps a small number of entries in fully associative form, so any track can sit in any slot, and it compares every stored tag against a request in the same cycle. A request sequencer presents a track number together with an operation. These operations exist: a read lookup, a write lookup that marks the line modified, and a fill that installs a track after a miss. The directory answers with hit or miss and the slot involved. The data array, the disk side and the parity engine sit outside and use the returned slot number.

Every entry has a valid flag, a modified (dirty) flag, a track tag and a saturating use counter. Replacement is least-frequently-used. A fill that misses first takes the lowest empty slot. If there is none, it takes the clean line with the smallest use count, and the lower index wins a tie. A modified line is never evicted, so it stays resident until the destage logic reports through the clean-slot input that the track is back on disk. If every slot holds a modified line, the fill is refused and a stall flag is raised until a line becomes clean. A line is always installed and evicted as one whole track.

Top module: `track_line_directory`

## Requirements
- R1: While reset is asserted, and for the two clock edges that the reset synchronizer needs after reset is released, `req_grant` and `rsp_valid` stay low. After reset every slot is invalid, so the first lookup misses.
- R2: A request whose track equals the tag of a valid slot hits. The response appears exactly one cycle after the grant, with `rsp_hit`=1 and `rsp_slot` equal to that slot, whatever slot the track sits in.
- R3: `req_op` is coded 0 for read, 1 for write, 2 for fill, and 3 acts as read. A read or write that misses returns `rsp_hit`=0 and `rsp_slot`=0 and changes no entry.
- R4: Each granted hit adds one to that line's use counter, which saturates at 255 and does not wrap. A newly filled line starts at 1.
- R5: A fill that misses installs the track in the lowest-indexed invalid slot if one exists, and reports that slot with `rsp_hit`=0.
- R6: With no invalid slot, a fill miss replaces the valid clean line with the lowest use count. The lowest index breaks a tie.
- R7: A dirty line is never chosen as a victim. A write hit sets the line's dirty flag. A fill installs the line dirty when `req_dirty`=1. A fill that hits behaves as a hit (`rsp_hit`=1, counter incremented) and sets the dirty flag if `req_dirty`=1.
- R8: When a fill misses and every slot is valid and dirty, `alloc_fail` is high, `req_grant` is low and no entry changes. This lasts until a line is cleaned.
- R9: `set_clean_valid` clears the dirty flag of slot `set_clean_slot` at the next edge. If a granted request marks the same slot dirty in the same cycle, the slot stays dirty.
- R10: `req_grant` is high exactly when `req_valid` is high, reset is over and the request is not stalled. `rsp_valid` is high exactly in the cycle after a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 fill, 3 read |
| req_track | input | 20 | Track number of the request |
| req_dirty | input | 1 | Fill marks the line modified |
| req_grant | output | 1 | Request accepted this cycle |
| alloc_fail | output | 1 | Fill stalled: no replaceable slot |
| set_clean_valid | input | 1 | Destage of a slot finished |
| set_clean_slot | input | 3 | Slot whose dirty flag is cleared |
| rsp_valid | output | 1 | Response for the request granted last cycle |
| rsp_hit | output | 1 | Response was a hit |
| rsp_slot | output | 3 | Hit slot, or the slot filled |

## Verification
The bench drives one counter to more than 255 hits and then triggers a replacement. A counter that wrapped would drop to a low value and evict the most-used line. Equal counts and clean lines sitting next to dirty ones test victim choice, where a selector with a strict/non-strict comparison swapped, or one that ignored the dirty flag, would pick the wrong slot or throw away modified data. The bench makes every slot dirty so that a fill must stall, then sends a clean-slot pulse in the same cycle as a write to that slot, and then a clean pulse alone: a directory that did not stall, or that let the clean win over the write, would grant the fill early. A long pseudo-random mix over a track space larger than the directory exercises hits, evictions and refusals against a model in the bench.

// File: rtl/tld_pkg.sv
package tld_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FILL  = 2'd2,
    OP_READ2 = 2'd3
  } tld_op_e;

endpackage

// File: rtl/tld_match.sv
module tld_match #(
  parameter int N_SLOTS = 8,
  parameter int TAG_W   = 20,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]            valid,
  input  logic [N_SLOTS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              key,
  output logic [N_SLOTS-1:0]            hit_vec,
  output logic                          hit,
  output logic [SLOT_W-1:0]             hit_idx
);

  genvar g;
  generate
    for (g = 0; g < N_SLOTS; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | SLOT_W'(i);
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/tld_victim.sv
module tld_victim #(
  parameter int N_SLOTS = 8,
  parameter int CNT_W   = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]            valid,
  input  logic [N_SLOTS-1:0]            dirty,
  input  logic [N_SLOTS-1:0][CNT_W-1:0] cnt,
  output logic                          found,
  output logic [SLOT_W-1:0]             idx
);

  logic              inv_found;
  logic [SLOT_W-1:0] inv_idx;
  logic              lfu_found;
  logic [SLOT_W-1:0] lfu_idx;
  logic [CNT_W-1:0]  lfu_cnt;

  // lowest-index empty slot
  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (!valid[i] && !inv_found) begin
        inv_found = 1'b1;
        inv_idx   = SLOT_W'(i);
      end
    end
  end

  // least-used clean slot; strict compare keeps the lower index on a tie
  always_comb begin
    lfu_found = 1'b0;
    lfu_idx   = '0;
    lfu_cnt   = '1;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (valid[i] && !dirty[i] && (!lfu_found || (cnt[i] < lfu_cnt))) begin
        lfu_found = 1'b1;
        lfu_idx   = SLOT_W'(i);
        lfu_cnt   = cnt[i];
      end
    end
  end

  assign found = inv_found | lfu_found;
  assign idx   = inv_found ? inv_idx : lfu_idx;

endmodule

// File: rtl/track_line_directory.sv
module track_line_directory
  import tld_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int TAG_W   = 20,
  parameter int CNT_W   = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [TAG_W-1:0]  req_track,
  input  logic              req_dirty,
  output logic              req_grant,
  output logic              alloc_fail,
  input  logic              set_clean_valid,
  input  logic [SLOT_W-1:0] set_clean_slot,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [SLOT_W-1:0] rsp_slot
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_NEW = CNT_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  // directory state
  logic [N_SLOTS-1:0]            valid_q, valid_d;
  logic [N_SLOTS-1:0]            dirty_q, dirty_d;
  logic [N_SLOTS-1:0][TAG_W-1:0] tag_q,   tag_d;
  logic [N_SLOTS-1:0][CNT_W-1:0] cnt_q,   cnt_d;
  logic                          rsp_valid_d, rsp_hit_d;
  logic [SLOT_W-1:0]             rsp_slot_d;

  logic [N_SLOTS-1:0] hit_vec;
  logic               hit;
  logic [SLOT_W-1:0]  hit_idx;
  logic               vic_found;
  logic [SLOT_W-1:0]  vic_idx;

  tld_match #(.N_SLOTS(N_SLOTS), .TAG_W(TAG_W)) i_match (
    .valid   (valid_q),
    .tags    (tag_q),
    .key     (req_track),
    .hit_vec (hit_vec),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  tld_victim #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) i_victim (
    .valid (valid_q),
    .dirty (dirty_q),
    .cnt   (cnt_q),
    .found (vic_found),
    .idx   (vic_idx)
  );

  logic              is_fill, is_write, need_alloc, state_en;
  logic              mark_dirty;
  logic [SLOT_W-1:0] mark_idx;

  assign is_fill    = (req_op == OP_FILL);
  assign is_write   = (req_op == OP_WRITE);
  assign need_alloc = is_fill && !hit;
  assign alloc_fail = req_valid && need_alloc && !vic_found;
  assign req_grant  = req_valid && srst_n && !alloc_fail;
  assign state_en   = req_grant || set_clean_valid;

  assign mark_dirty = req_grant && (hit ? (is_write || (is_fill && req_dirty))
                                        : (need_alloc && req_dirty));
  assign mark_idx   = hit ? hit_idx : vic_idx;

  // next state
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    cnt_d   = cnt_q;
    if (set_clean_valid) dirty_d[set_clean_slot] = 1'b0;
    if (req_grant) begin
      if (hit) begin
        if (cnt_q[hit_idx] != CNT_MAX) cnt_d[hit_idx] = cnt_q[hit_idx] + CNT_NEW;
        if (is_write || (is_fill && req_dirty)) dirty_d[hit_idx] = 1'b1;
      end else if (need_alloc) begin
        valid_d[vic_idx] = 1'b1;
        tag_d[vic_idx]   = req_track;
        cnt_d[vic_idx]   = CNT_NEW;
        dirty_d[vic_idx] = req_dirty;
      end
    end
    rsp_valid_d = req_grant;
    rsp_hit_d   = hit;
    rsp_slot_d  = hit ? hit_idx : (need_alloc ? vic_idx : '0);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      tag_q   <= tag_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_slot  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (req_grant) begin
        rsp_hit  <= rsp_hit_d;
        rsp_slot <= rsp_slot_d;
      end
    end
  end

  // checks
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(hit_vec)); // R2

  AST_RSP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!srst_n)
    req_grant |=> rsp_valid); // R10

  AST_NO_RSP_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!srst_n)
    !req_grant |=> !rsp_valid); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!srst_n)
    alloc_fail |-> !req_grant); // R8

  AST_VICTIM_CLEAN: assert property (@(posedge clk) disable iff (!srst_n)
    vic_found |-> !(valid_q[vic_idx] && dirty_q[vic_idx])); // R7

  AST_CLEAN_TAKES: assert property (@(posedge clk) disable iff (!srst_n)
    (set_clean_valid && !(mark_dirty && (mark_idx == set_clean_slot)))
      |=> !dirty_q[$past(set_clean_slot)]); // R9

  genvar s;
  generate
    for (s = 0; s < N_SLOTS; s++) begin : g_slot_chk
      AST_DIRTY_RESIDENT: assert property (@(posedge clk) disable iff (!srst_n)
        (valid_q[s] && dirty_q[s] && !(set_clean_valid && (set_clean_slot == SLOT_W'(s))))
          |=> (valid_q[s] && $stable(tag_q[s]))); // R7

      AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!srst_n)
        valid_q[s] |-> (cnt_q[s] != '0)); // R4
    end
  endgenerate

endmodule

// File: tb/test_track_line_directory.sv
`timescale 1ns/1ps
module test_track_line_directory;

  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [19:0] req_track;
  logic        req_dirty;
  logic        req_grant;
  logic        alloc_fail;
  logic        set_clean_valid;
  logic [2:0]  set_clean_slot;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [2:0]  rsp_slot;

  always #5 clk = ~clk;

  track_line_directory i_track_line_directory (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_op          (req_op),
    .req_track       (req_track),
    .req_dirty       (req_dirty),
    .req_grant       (req_grant),
    .alloc_fail      (alloc_fail),
    .set_clean_valid (set_clean_valid),
    .set_clean_slot  (set_clean_slot),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_slot        (rsp_slot)
  );

  int checks = 0;
  int errors = 0;

  // reference model of the directory contents
  bit m_valid [NS];
  bit m_dirty [NS];
  int m_tag   [NS];
  int m_cnt   [NS];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_victim(output bit found, output int idx);
    int best;
    found = 0; idx = 0; best = 0;
    for (int i = 0; i < NS; i++)
      if (!m_valid[i] && !found) begin found = 1; idx = i; end
    if (!found)
      for (int i = 0; i < NS; i++)
        if (m_valid[i] && !m_dirty[i] && (!found || m_cnt[i] < best)) begin
          found = 1; idx = i; best = m_cnt[i];
        end
  endtask

  // one request cycle; rq names the requirement for the slot/hit check
  task automatic op(input int o, input int trk, input bit d,
                    input bit scv, input int scs, input string rq);
    bit hit, fnd, fill, need, stall;
    int hidx, vidx, eslot;
    hit = 0; hidx = 0;
    for (int i = 0; i < NS; i++)
      if (m_valid[i] && m_tag[i] == trk) begin hit = 1; hidx = i; end
    model_victim(fnd, vidx);
    fill  = (o == 2);
    need  = fill && !hit;
    stall = need && !fnd;
    eslot = hit ? hidx : (need ? vidx : 0);

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(o); req_track = 20'(trk); req_dirty = d;
    set_clean_valid = scv; set_clean_slot = 3'(scs);
    #1;
    check(req_grant == !stall, "R10", int'(req_grant), int'(!stall));
    check(alloc_fail == stall, "R8", int'(alloc_fail), int'(stall));
    @(posedge clk);
    #1;
    req_valid = 1'b0; set_clean_valid = 1'b0;
    check(rsp_valid == !stall, "R10", int'(rsp_valid), int'(!stall));
    if (!stall) begin
      check(rsp_hit == hit, rq, int'(rsp_hit), int'(hit));
      check(int'(rsp_slot) == eslot, rq, int'(rsp_slot), eslot);
    end
    // model update: clean first, then the granted request
    if (scv) m_dirty[scs] = 0;
    if (!stall) begin
      if (hit) begin
        if (m_cnt[hidx] < 255) m_cnt[hidx]++;
        if (o == 1 || (fill && d)) m_dirty[hidx] = 1;
      end else if (need) begin
        m_valid[vidx] = 1; m_tag[vidx] = trk; m_cnt[vidx] = 1; m_dirty[vidx] = d;
      end
    end
  endtask

  bit done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NS; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_track = '0; req_dirty = 1'b0;
    set_clean_valid = 1'b0; set_clean_slot = '0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; #1;
    check(req_grant == 1'b0, "R1", int'(req_grant), 0);
    check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    op(0, 5, 0, 0, 0, "R1");                 // empty directory misses
    op(1, 6, 0, 0, 0, "R3");                 // write miss, no change
    for (int i = 0; i < NS; i++) op(2, 100 + i, 0, 0, 0, "R5"); // fill slots 0..7 in order
    for (int i = 0; i < NS; i++)
      for (int k = 0; k < i; k++) op(0, 100 + i, 0, 0, 0, "R2");
    op(3, 107, 0, 0, 0, "R3");               // code 3 acts as read
    for (int k = 0; k < 300; k++) op(0, 100, 0, 0, 0, "R4"); // slot 0 saturates
    op(2, 200, 0, 0, 0, "R4");               // slot 1 (count 2) evicted, not wrapped slot 0
    op(2, 201, 0, 0, 0, "R6");               // new line in slot 1 has count 1
    op(0, 201, 0, 0, 0, "R2");               // slot1 count 2
    op(0, 102, 0, 0, 0, "R2");               // slot2 count 4
    op(0, 201, 0, 0, 0, "R2");               // slot1 count 3 tie with slot 2? slot2=4
    op(0, 201, 0, 0, 0, "R2");               // slot1 count 4, tie with slot2
    op(2, 202, 0, 0, 0, "R6");               // tie -> lowest index slot 1
    op(1, 202, 0, 0, 0, "R7");               // slot 1 dirty
    op(2, 203, 0, 0, 0, "R7");               // slot 1 skipped
    op(2, 203, 1, 0, 0, "R7");               // fill hit sets dirty
    for (int i = 0; i < NS; i++) op(1, m_tag[i], 0, 0, 0, "R7");
    op(2, 300, 0, 0, 0, "R8");               // all dirty: stall
    op(2, 300, 0, 0, 0, "R8");
    op(1, m_tag[4], 0, 1, 4, "R9");          // write wins over clean
    op(2, 300, 0, 0, 0, "R9");               // still stalled
    op(0, 1, 0, 1, 4, "R9");                 // clean slot 4
    op(2, 300, 1, 0, 0, "R9");               // goes to slot 4, dirty
    op(2, 301, 0, 0, 0, "R8");               // stalled again
    for (int i = 0; i < NS; i++) op(0, 0, 0, 1, i, "R9");

    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      int o, t, sc;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      o  = int'(lf[1:0]);
      t  = 500 + int'(lf[5:2]) % 12;
      sc = int'(lf[10:8]);
      op(o, t, lf[11] & lf[12], (lf[15:13] == 3'd0), sc, "R6");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule